// File: doc/BRIEF.md
# Interval Timer with Watchdog and Stabilization Wait

This block is a free-running 8-bit interval timer. A prescaler divides the system clock, and one of its taps clocks the counter. Each time the counter wraps from its top value to zero, the block sets a sticky interrupt flag and drives a single-cycle pulse on its timer output.

The same wrap events advance a small watchdog counter. If software does not clear the watchdog often enough, the block issues a one-cycle system reset request. Writing a disable code to the watchdog mode register turns the watchdog off.

After reset or a wake request, the first wrap also marks the end of the oscillator stabilization wait, and a level output reports it. Software reaches the block through a write strobe with a 2-bit address and 8-bit data. Readback is combinational on the same address lines.

Top module: `interval_timer_wdt`

Register addresses: 0 is the mode register, 1 is the count (read only), 2 is the watchdog mode register, and 3 is the control/status register.

## Requirements
- R1: The counter advances by one on each tick of the selected prescaler tap. It reads back at address 1. Writes to address 1 leave it unchanged.
- R2: When the counter wraps from 255 to 0, the interrupt flag is set. The flag is sticky until a write to address 3 with bit 1 set, and it reads back at address 3 bit 1.
- R3: Each wrap produces a timer output pulse exactly one clock long, in the cycle right after the wrap edge.
- R4: Mode bits 2..0 select the tap. Code 000 gives a period of 2^P system clocks, 011 gives 2^(P-3), 101 gives 2^(P-5) and 111 gives 2^(P-7), where P is the prescaler width (default 12). Every other code gives 2^P. After reset the code is 011.
- R5: A write to address 0 with bit 3 set clears both the counter and the prescaler. One wrap then takes exactly 256 tap periods. Address 0 reads back the tap code with bit 3 as zero.
- R6: The watchdog mode register is at address 2 and resets to 00H. While it holds 5AH the watchdog is disabled: its counter stays at zero and it never requests a reset.
- R7: A write to address 3 with bit 0 set clears the watchdog counter. That bit always reads back as zero.
- R8: While the watchdog is enabled, the eighth wrap after a clear raises the reset request for one cycle, and the watchdog counter restarts from zero.
- R9: The stabilization-done output is low after reset, and it is low in the cycle after a wake request. A wake request clears the counter and the prescaler. The output rises together with the next wrap pulse, so the default wait after reset is 256 * 2^(P-3) clocks (131072 at defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for write and readback |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Readback of the addressed register |
| wake_req | input | 1 | Wake from stop mode; restarts the stabilization wait |
| irq_flag | output | 1 | Sticky interval interrupt request |
| tmr_pulse | output | 1 | One-cycle pulse on each counter wrap |
| wdt_rst | output | 1 | One-cycle system reset request from the watchdog |
| stab_done | output | 1 | High once the stabilization wait has ended |

## Verification
The assertions assume that a wake request and a restart never come closer together than one tap period. They also assume that watchdog expiries are separated by at least eight wraps, so every pulse-width property can see a quiet cycle after each event.

The stimulus keeps to these limits. Wake and restart events are always at least a full interval apart. A smaller prescaler (P = 9) keeps each interval short. All eight tap codes are swept, and counter values are computed from the elapsed cycle count.

// File: rtl/itw_pkg.sv
// Shared definitions for the interval timer: register addresses and tap decode.
// Assumes the prescaler is wider than the largest tap shift (7).
package itw_pkg;

    typedef enum logic [1:0] {
        REG_MODE   = 2'd0,
        REG_COUNT  = 2'd1,
        REG_WDMODE = 2'd2,
        REG_CTRL   = 2'd3
    } itw_reg_e;

    localparam logic [2:0] SEL_DEFAULT = 3'b011;

    // Number of prescaler bits dropped from the full period for each tap code.
    function automatic int unsigned tap_shift(input logic [2:0] sel);
        case (sel)
            3'b011:  return 3;
            3'b101:  return 5;
            3'b111:  return 7;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/itw_prescaler.sv
// Free-running prescaler. It emits one tick per 2^(PRESC_W - shift) clocks,
// where the shift comes from the tap code.
// Assumes that clear_i restarts the tick phase so that the first tick comes one full period later.
module itw_prescaler
    import itw_pkg::*;
#(
    parameter int PRESC_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic [2:0] sel_i,
    output logic       tick_o
);

    logic [PRESC_W-1:0] presc_q;
    logic [PRESC_W-1:0] mask;

    // Divider counter: it restarts on reset or on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) presc_q <= '0;
        else                   presc_q <= presc_q + 1'b1;
    end

    // Tick when all the low bits of the selected tap are ones.
    always_comb begin
        mask   = {PRESC_W{1'b1}} >> tap_shift(sel_i);
        tick_o = ((presc_q & mask) == mask);
    end

endmodule

// File: rtl/itw_counter.sv
// Wrapping interval counter. It reports the wrap combinationally and also as a registered one-cycle pulse.
// Assumes that clear_i has priority over a tick in the same cycle.
module itw_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o,
    output logic             pulse_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             pulse_q;

    // Wrap happens on a tick at the top count, unless a clear overrides it.
    assign wrap_o = tick_i && (&cnt_q) && !clear_i;

    // Counter: cleared by reset or restart, and advanced on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (tick_i)       cnt_q <= cnt_q + 1'b1;
    end

    // Output pulse: one cycle, registered from the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= wrap_o;
    end

    assign cnt_o   = cnt_q;
    assign pulse_o = pulse_q;

endmodule

// File: rtl/itw_watchdog.sv
// Watchdog: it counts wraps and requests a reset on the overflow that follows
// the top count. Assumes a software clear beats a wrap in the same cycle; disable holds it at zero.
module itw_watchdog #(
    parameter int WDT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic clear_i,
    input  logic wrap_i,
    output logic fire_o
);

    logic [WDT_W-1:0] wcnt_q;
    logic             fire_q;
    logic             expire;

    assign expire = enable_i && !clear_i && wrap_i && (&wcnt_q);

    // Wrap count: held at zero while disabled or cleared, and restarted after it expires.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i || clear_i) wcnt_q <= '0;
        else if (wrap_i)                    wcnt_q <= wcnt_q + 1'b1;
    end

    // Reset request: one registered cycle per expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) fire_q <= 1'b0;
        else        fire_q <= expire;
    end

    assign fire_o = fire_q;

endmodule

// File: rtl/interval_timer_wdt.sv
// Top: register port, interrupt flag, stabilization flag, and the wiring of
// the prescaler, counter and watchdog. Assumes one register access per cycle and combinational readback.
module interval_timer_wdt
    import itw_pkg::*;
#(
    parameter int          PRESC_W = 12,
    parameter int          CNT_W   = 8,
    parameter int          WDT_W   = 3,
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  WDT_KEY = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wake_req,
    output logic              irq_flag,
    output logic              tmr_pulse,
    output logic              wdt_rst,
    output logic              stab_done
);

    localparam int RESTART_BIT = 3;

    logic [2:0]        sel_q;
    logic [DATA_W-1:0] wdmode_q;
    logic              irq_q;
    logic              stab_q;
    logic              restart;
    logic              clear_cnt;
    logic              wdt_clr;
    logic              irq_clr;
    logic              tick;
    logic              wrap;
    logic [CNT_W-1:0]  cnt_q;

    assign restart   = wr_en && (addr == REG_MODE) && wr_data[RESTART_BIT];
    assign clear_cnt = restart || wake_req;
    assign wdt_clr   = wr_en && (addr == REG_CTRL) && wr_data[0];
    assign irq_clr   = wr_en && (addr == REG_CTRL) && wr_data[1];

    // Mode register: the tap select.
    always_ff @(posedge clk) begin
        if (!rst_n)                          sel_q <= SEL_DEFAULT;
        else if (wr_en && addr == REG_MODE)  sel_q <= wr_data[2:0];
    end

    // Watchdog mode register: the key value disables the watchdog.
    always_ff @(posedge clk) begin
        if (!rst_n)                           wdmode_q <= '0;
        else if (wr_en && addr == REG_WDMODE) wdmode_q <= wr_data;
    end

    // Interrupt flag: set on a wrap (set beats clear), cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (wrap)    irq_q <= 1'b1;
        else if (irq_clr) irq_q <= 1'b0;
    end

    // Stabilization flag: low after reset or wake, high from the next wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || wake_req) stab_q <= 1'b0;
        else if (wrap)          stab_q <= 1'b1;
    end

    itw_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_cnt),
        .sel_i   (sel_q),
        .tick_o  (tick)
    );

    itw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_cnt),
        .tick_i  (tick),
        .cnt_o   (cnt_q),
        .wrap_o  (wrap),
        .pulse_o (tmr_pulse)
    );

    itw_watchdog #(.WDT_W(WDT_W)) u_wdt (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (wdmode_q != DATA_W'(WDT_KEY)),
        .clear_i  (wdt_clr),
        .wrap_i   (wrap),
        .fire_o   (wdt_rst)
    );

    // Readback mux: the restart bit and the watchdog clear bit read back as zero.
    always_comb begin
        case (addr)
            REG_MODE:   rd_data = DATA_W'(sel_q);
            REG_COUNT:  rd_data = DATA_W'(cnt_q);
            REG_WDMODE: rd_data = wdmode_q;
            default:    rd_data = DATA_W'({irq_q, 1'b0});
        endcase
    end

    assign irq_flag  = irq_q;
    assign stab_done = stab_q;

endmodule

// File: rtl/itw_checker.sv
// Temporal checks for interval_timer_wdt. They are attached through bind and observe the ports plus the counter value and the restart strobe.
module itw_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wake_req,
    input logic             clear_cnt,
    input logic             tmr_pulse,
    input logic             irq_flag,
    input logic             wdt_rst,
    input logic             stab_done,
    input logic [CNT_W-1:0] cnt
);

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_pulse |=> !tmr_pulse); // R3

    AST_IRQ_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_pulse |-> irq_flag); // R2

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_pulse |-> (cnt == '0)); // R2

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clear_cnt |=> (cnt == '0) && !tmr_pulse); // R5

    AST_WDT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst); // R8

    AST_WDT_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> tmr_pulse); // R8

    AST_WAKE_DROPS_STAB: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !stab_done); // R9

    AST_STAB_RISES_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stab_done) |-> tmr_pulse); // R9

endmodule

bind interval_timer_wdt itw_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wake_req  (wake_req),
    .clear_cnt (clear_cnt),
    .tmr_pulse (tmr_pulse),
    .irq_flag  (irq_flag),
    .wdt_rst   (wdt_rst),
    .stab_done (stab_done),
    .cnt       (cnt_q)
);

// File: tb/interval_timer_wdt_test.sv
// Self-checking bench. It uses a reduced prescaler (P = 9) and sweeps every tap code.
// Expected counts come from elapsed cycles; m is the number of edges since the last clear.
module interval_timer_wdt_test;

    localparam int P = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd1;
    logic [7:0] wr_data = 8'h00;
    logic       wake_req = 1'b0;
    wire  [7:0] rd_data;
    wire        irq_flag, tmr_pulse, wdt_rst, stab_done;

    int checks = 0;
    int fails = 0;
    int m = 0;
    int rst_pulses = 0;

    interval_timer_wdt #(.PRESC_W(P)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .wake_req  (wake_req),
        .irq_flag  (irq_flag),
        .tmr_pulse (tmr_pulse),
        .wdt_rst   (wdt_rst),
        .stab_done (stab_done)
    );

    always #10 clk = ~clk;

    always @(posedge clk) if (wdt_rst) rst_pulses++;

    function automatic int tap_exp(input int sel);
        case (sel)
            3: return P - 3;
            5: return P - 5;
            7: return P - 7;
            default: return P;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at m=%0d: actual=%0d expected=%0d", tag, m, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        m += n;
    endtask

    task automatic wait_to(input int t);
        if (t > m) step(t - m);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd1;
        m += 1;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic restart(input int sel);
        wr(2'd0, 8'h08 | 8'(sel));
        m = 0;
    endtask

    task automatic wake();
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        m = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog timeout: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int v;
        int base;
        int dflt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        m = 0;

        // Reset state
        check("R9 stab low after reset", stab_done, 0);
        check("R2 irq low after reset", irq_flag, 0);
        check("R3 pulse low after reset", tmr_pulse, 0);
        check("R8 no reset request", wdt_rst, 0);
        rd(2'd0, v); check("R4 default tap code", v, 3);
        rd(2'd2, v); check("R6 wdmode reset value", v, 0);
        rd(2'd1, v); check("R1 count after reset", v, 0);

        // Default stabilization wait
        dflt = 256 << (P - 3);
        wait_to(dflt - 1);
        check("R9 stab still low before wait ends", stab_done, 0);
        check("R2 irq low before first wrap", irq_flag, 0);
        step(1);
        check("R9 stab high at default wait", stab_done, 1);
        check("R2 irq set on wrap", irq_flag, 1);
        check("R3 pulse on wrap", tmr_pulse, 1);
        rd(2'd1, v); check("R2 count wrapped to zero", v, 0);
        step(1);
        check("R3 pulse lasts one cycle", tmr_pulse, 0);

        // Disable watchdog, clear irq
        wr(2'd2, 8'h5A);
        rd(2'd2, v); check("R6 wdmode readback", v, 'h5A);
        wr(2'd3, 8'h02);
        check("R2 irq cleared by software", irq_flag, 0);

        // Sweep every tap code
        for (int s = 0; s < 8; s++) begin
            restart(s);
            rd(2'd0, v); check("R5 mode readback with restart bit zero", v, s);
            wait_to(1000);
            wr(2'd1, 8'hA5);
            wait_to(3000);
            rd(2'd1, v);
            check("R4 R1 count after 3000 cycles", v, (3000 >> tap_exp(s)) & 255);
        end

        // Interval at the fastest tap
        restart(7);
        wr(2'd3, 8'h02);
        wait_to(1023);
        rd(2'd1, v); check("R1 count at top", v, 255);
        check("R3 no pulse before wrap", tmr_pulse, 0);
        check("R2 irq clear before wrap", irq_flag, 0);
        step(1);
        check("R3 pulse at 256 ticks", tmr_pulse, 1);
        check("R2 irq set at wrap", irq_flag, 1);
        step(1);
        check("R3 pulse ends", tmr_pulse, 0);
        check("R2 irq sticky", irq_flag, 1);
        wait_to(2048);
        check("R3 second pulse one interval later", tmr_pulse, 1);

        // Watchdog expiry
        wr(2'd2, 8'h00);
        restart(7);
        wr(2'd3, 8'h01);
        rd(2'd3, v); check("R7 clear bit reads zero", v & 1, 0);
        base = rst_pulses;
        wait_to(8 * 1024 - 1);
        check("R8 no request before eighth wrap", rst_pulses - base, 0);
        step(1);
        check("R8 request on eighth wrap", wdt_rst, 1);
        step(1);
        check("R8 request one cycle", wdt_rst, 0);

        // Clearing postpones expiry
        restart(7);
        wr(2'd3, 8'h01);
        wait_to(5 * 1024 + 10);
        wr(2'd3, 8'h01);
        base = rst_pulses;
        wait_to(13 * 1024 - 1);
        check("R7 clear postponed expiry", rst_pulses - base, 0);
        check("R7 no request yet", wdt_rst, 0);
        step(1);
        check("R7 R8 request eight wraps after clear", wdt_rst, 1);

        // Disabled watchdog
        wr(2'd2, 8'h5A);
        restart(7);
        base = rst_pulses;
        wait_to(17 * 1024);
        check("R6 disabled watchdog silent", rst_pulses - base, 0);

        // Wake restarts stabilization
        step(100);
        wake();
        check("R9 stab low after wake", stab_done, 0);
        rd(2'd1, v); check("R9 wake clears count", v, 0);
        wait_to(1023);
        check("R9 stab low before wrap", stab_done, 0);
        step(1);
        check("R9 stab high on wrap", stab_done, 1);
        check("R9 wrap pulse with stab", tmr_pulse, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule